// File: doc/BRIEF.md
# Barrel Shifter with Flags

A 32-bit shift unit for a processor datapath. Each accepted operation takes a source operand, a shift kind, and a shift amount. The amount comes either from an immediate field or from the low byte of a register value. The unit returns the shifted value in a separate output and leaves the operand untouched.

Alongside the shifted value, the unit keeps three flag bits: negative, zero and carry. A flag-enable input decides whether an operation writes them. The stored carry is also the bit that enters the top of the result in the one-bit rotate-through-carry kind. Its value therefore links one operation to the next.

The result can leave through an output register (the default) or straight from the shift logic. Instruction decode, condition checking and register writeback lie outside the unit.

Top module: `barrel_shift_flags`

## Requirements
- R1: `kind` selects the operation: 0 arithmetic right, 1 logical left, 2 logical right, 3 rotate right, 4 rotate right through carry. Codes 5 to 7 pass the operand through and leave the carry as it is. With `amt_sel`=1 the amount is `amt_reg[7:0]`; with `amt_sel`=0 it is the 6-bit `amt_imm`.
- R2: Logical left by n. For n=0 the result equals the operand and the carry is kept. For 1≤n≤31 the carry is operand bit 32−n. For n=32 the result is 0 and the carry is operand bit 0. For n>32 both the result and the carry are 0.
- R3: Logical right by n. For n=0 the result equals the operand and the carry is kept. For 1≤n≤31 the carry is operand bit n−1. For n=32 the result is 0 and the carry is operand bit 31. For n>32 both are 0.
- R4: Arithmetic right by n fills the vacated bits with bit 31. For 1≤n≤31 the carry is operand bit n−1. For n≥32 every result bit and the carry equal operand bit 31. For n=0 the operand passes through and the carry is kept.
- R5: Rotate right uses n mod 32. For n=0 the operand passes through and the carry is kept. For a nonzero multiple of 32 the result equals the operand and the carry is bit 31. Otherwise the carry is result bit 31.
- R6: Rotate right through carry shifts by exactly one place. The stored carry enters bit 31 and operand bit 0 becomes the new carry. The amount inputs are ignored.
- R7: With `flag_en`=1, the negative flag takes result bit 31 and the zero flag is set exactly when the result is all zeros. The carry follows R2 to R6.
- R8: With `flag_en`=0, or when no operation is accepted, all three flags keep their values.
- R9: In register-amount mode, bits 31:8 of `amt_reg` have no effect.
- R10: With the output register, `result` and `out_valid` appear one cycle after `in_valid`. The flags update on that same edge.
- R11: Reset clears `result`, `out_valid` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| kind | input | 3 | Shift kind code (R1) |
| src | input | 32 | Operand |
| amt_sel | input | 1 | 1: register amount, 0: immediate |
| amt_imm | input | 6 | Immediate amount |
| amt_reg | input | 32 | Register amount value; only bits 7:0 used |
| flag_en | input | 1 | Write flags for this operation |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Shifted value |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |

## Verification
The hardest state to reach from the ports is a specific stored carry going into a rotate-through-carry step, or into a zero-amount shift that must leave the carry alone. That carry is set only by an earlier flag-writing operation.

The stimulus therefore runs chains of operations. Some earlier shifts deliberately set or clear the carry, some later ones have `flag_en` low, and then a rotate-through-carry or a zero-amount shift follows. A bench model tracks the flags the same way, one operation at a time.

Register amounts are swept across 0, 1, 31, 32, 33 and 255, with random upper bits, so that the boundaries beyond 32 are covered.

// File: rtl/barrel_shift_flags.sv
module barrel_shift_flags #(
  parameter int W       = 32,
  parameter int AW      = 8,
  parameter int IW      = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    kind,
  input  logic [W-1:0]  src,
  input  logic          amt_sel,
  input  logic [IW-1:0] amt_imm,
  input  logic [W-1:0]  amt_reg,
  input  logic          flag_en,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          neg_o,
  output logic          zero_o,
  output logic          carry_o
);
  localparam int SW = $clog2(W);

  logic [AW-1:0] n;
  logic [SW-1:0] rot_k;
  logic [W:0]    lsl_w, lsr_w, asr_w;
  logic [W-1:0]  ror_v, res;
  logic          c_new, c_upd;

  // R1, R9: only the low byte of the register amount is looked at
  assign n     = amt_sel ? amt_reg[AW-1:0] : AW'(amt_imm);
  assign rot_k = n[SW-1:0];

  assign lsl_w = {1'b0, src} << n;
  assign lsr_w = {src, 1'b0} >> n;
  assign asr_w = $unsigned($signed({src, 1'b0}) >>> n);
  assign ror_v = (src >> rot_k) | (src << (W - int'(rot_k)));

  always_comb begin
    res   = src;
    c_new = carry_o;
    c_upd = 1'b0;
    case (kind)
      3'd0: begin res = asr_w[W:1];   c_new = asr_w[0];    c_upd = (n != '0); end
      3'd1: begin res = lsl_w[W-1:0]; c_new = lsl_w[W];    c_upd = (n != '0); end
      3'd2: begin res = lsr_w[W:1];   c_new = lsr_w[0];    c_upd = (n != '0); end
      3'd3: begin res = ror_v;        c_new = ror_v[W-1];  c_upd = (n != '0); end
      3'd4: begin res = {carry_o, src[W-1:1]}; c_new = src[0]; c_upd = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      neg_o   <= 1'b0;
      zero_o  <= 1'b0;
      carry_o <= 1'b0;
    end else if (in_valid && flag_en) begin
      neg_o  <= res[W-1];
      zero_o <= (res == '0);
      if (c_upd) carry_o <= c_new;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          result    <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) result <= res;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = res;
    end
  endgenerate
endmodule

module barrel_shift_flags_chk #(
  parameter int W       = 32,
  parameter int AW      = 8,
  parameter int IW      = 6,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    kind,
  input logic [W-1:0]  src,
  input logic          amt_sel,
  input logic [IW-1:0] amt_imm,
  input logic [AW-1:0] amt_lo,
  input logic          flag_en,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          neg_o,
  input logic          zero_o,
  input logic          carry_o
);
  logic amt0;
  assign amt0 = amt_sel ? (amt_lo == '0) : (amt_imm == '0);

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || !flag_en) |=> $stable({neg_o, zero_o, carry_o}));

  assert_nz_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && in_valid && flag_en) |=> (zero_o == (result == '0)) && (neg_o == result[W-1]));

  assert_rrx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && in_valid && kind == 3'd4) |=> result == {$past(carry_o), $past(src[W-1:1])});

  assert_lsl_zero_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && in_valid && kind == 3'd1 && amt0) |=> result == $past(src));

  assert_zero_amt_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind <= 3'd3 && amt0) |=> $stable(carry_o));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    REG_OUT |=> out_valid == $past(in_valid));
endmodule

bind barrel_shift_flags barrel_shift_flags_chk #(.W(W), .AW(AW), .IW(IW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .kind(kind), .src(src),
  .amt_sel(amt_sel), .amt_imm(amt_imm), .amt_lo(amt_reg[AW-1:0]), .flag_en(flag_en),
  .out_valid(out_valid), .result(result), .neg_o(neg_o), .zero_o(zero_o), .carry_o(carry_o)
);

// File: tb/tb_barrel_shift_flags.sv
module tb_barrel_shift_flags;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, amt_sel = 1'b0, flag_en = 1'b0;
  logic [2:0]  kind = '0;
  logic [31:0] src = '0, amt_reg = '0;
  logic [5:0]  amt_imm = '0;
  logic        out_valid, neg_o, zero_o, carry_o;
  logic [31:0] result;

  always #5 clk = ~clk;

  barrel_shift_flags dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .kind(kind), .src(src),
    .amt_sel(amt_sel), .amt_imm(amt_imm), .amt_reg(amt_reg), .flag_en(flag_en),
    .out_valid(out_valid), .result(result), .neg_o(neg_o), .zero_o(zero_o), .carry_o(carry_o)
  );

  typedef struct {
    logic [31:0] res;
    logic        n, z, c;
    string       tag;
    string       ftag;
  } exp_t;

  exp_t q[$];
  int   errors = 0, checks = 0;
  logic mneg = 0, mzero = 0, mcarry = 0;
  bit   done = 0;

  function automatic string ktag(input logic [2:0] k);
    case (k)
      3'd0: return "R4";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one-bit-step reference model, pushes expected item
  task automatic send(input logic [2:0] k, input logic [31:0] s, input bit sel,
                      input logic [5:0] imm, input logic [31:0] rg, input bit fe, input string tag);
    exp_t e;
    logic [31:0] x;
    logic c;
    int amt;
    amt = sel ? int'(rg[7:0]) : int'(imm);
    x = s;
    c = mcarry;
    if (k == 3'd4) begin
      c = x[0];
      x = {mcarry, x[31:1]};
    end else if (k <= 3'd3) begin
      for (int i = 0; i < amt; i++) begin
        case (k)
          3'd0: begin c = x[0];  x = {x[31], x[31:1]}; end
          3'd1: begin c = x[31]; x = {x[30:0], 1'b0}; end
          3'd2: begin c = x[0];  x = {1'b0, x[31:1]}; end
          default: begin c = x[0]; x = {x[0], x[31:1]}; end
        endcase
      end
    end
    if (fe) begin
      mneg = x[31];
      mzero = (x == 0);
      mcarry = c;
    end
    e.res = x; e.n = mneg; e.z = mzero; e.c = mcarry;
    e.tag = (tag == "") ? ktag(k) : tag;
    e.ftag = fe ? "R7" : "R8";
    @(negedge clk);
    q.push_back(e);
    in_valid = 1'b1; kind = k; src = s; amt_sel = sel; amt_imm = imm; amt_reg = rg; flag_en = fe;
  endtask

  task automatic idle(input int cyc);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (cyc - 1) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "unexpected out_valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(result == e.res, e.tag, "result", result, e.res);
          check({neg_o, zero_o, carry_o} == {e.n, e.z, e.c}, e.ftag, "flags NZC",
                {29'd0, neg_o, zero_o, carry_o}, {29'd0, e.n, e.z, e.c});
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int amts[6] = '{0, 1, 31, 32, 33, 255};
    logic [31:0] ops[4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000};
    repeat (3) @(negedge clk);
    // R11 reset state
    check(result == 0 && !out_valid, "R11", "result/valid after reset", result, 0);
    check({neg_o, zero_o, carry_o} == 3'b000, "R11", "flags after reset", {29'd0, neg_o, zero_o, carry_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2..R5 edge amounts from register (R1 register mode), upper bits random
    for (int k = 0; k < 4; k++)
      foreach (ops[o])
        foreach (amts[a]) begin
          send(3'(k), ops[o], 1'b1, 6'd0, {$urandom() & 32'hFFFF_FF00} | 32'(amts[a]), 1'b1, "");
        end

    // R1 immediate mode at legal boundaries
    send(3'd0, 32'h8000_0000, 1'b0, 6'd32, 32'hFF, 1'b1, "R4");
    send(3'd2, 32'h8000_0000, 1'b0, 6'd32, 32'h0, 1'b1, "R3");
    send(3'd1, 32'h1234_5678, 1'b0, 6'd0, 32'h20, 1'b1, "R2");
    send(3'd3, 32'h0000_0001, 1'b0, 6'd31, 32'h0, 1'b1, "R5");
    send(3'd5, 32'hDEAD_BEEF, 1'b0, 6'd3, 32'h0, 1'b1, "R1");

    // R6 chains: set carry, then rotate through it, then flags held (R8)
    send(3'd2, 32'h0000_0001, 1'b0, 6'd1, 32'h0, 1'b1, "R3");
    send(3'd4, 32'h0000_0002, 1'b0, 6'd9, 32'h0, 1'b1, "R6");
    send(3'd4, 32'h0000_0001, 1'b1, 6'd0, 32'h5, 1'b1, "R6");
    send(3'd4, 32'hFFFF_FFFE, 1'b0, 6'd0, 32'h0, 1'b0, "R6");
    send(3'd1, 32'h0000_0000, 1'b1, 6'd0, 32'h1, 1'b0, "R8");
    send(3'd3, 32'h8000_0000, 1'b1, 6'd0, 32'h40, 1'b1, "R5");
    send(3'd3, 32'h0000_0000, 1'b1, 6'd0, 32'h0, 1'b1, "R5");

    // R9 upper amount bits ignored
    send(3'd2, 32'hF000_000F, 1'b1, 6'd0, 32'hFFFF_FF04, 1'b1, "R9");
    send(3'd1, 32'hF000_000F, 1'b1, 6'd0, 32'h0001_0000, 1'b1, "R9");
    idle(3);

    // random mix incl. idle gaps
    for (int i = 0; i < 300; i++) begin
      int a;
      a = ($urandom() % 2) ? amts[$urandom() % 6] : int'($urandom() % 256);
      send(3'($urandom() % 5), $urandom(), 1'($urandom()), 6'($urandom()),
           {$urandom() & 32'hFFFF_FF00} | 32'(a), 1'($urandom()), "");
      if (i % 37 == 0) idle(2);
    end
    idle(4);
    check(q.size() == 0, "R10", "pending expected items", 32'(q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule